// File: doc/BRIEF.md
# XOR/Modulo Interleave Target Selector

This block picks which interleave target (host bridge) serves a given slot of an interleaved memory window. The address is formed from a window base, a slot position and a power-of-two granularity. The block then builds a target index from that address and the programmed configuration.

For power-of-two way counts, each index bit is the parity of the address ANDed with one programmable XOR mask. For 3, 6 and 12 ways, a divide-by-three remainder of an upper address field is also shifted above the parity bits and ORed into the index. This lets 6 and 12 ways mix both terms.

The result is registered, so `out_valid` and `out_idx` appear one clock after `in_valid`. A way count that the block does not support, or one that disagrees with the configured target count, yields no valid target.

Top module: `ilv_target_sel`

## Requirements
- R1: `out_valid` rises exactly one clock after an accepted `in_valid`. It is low in any cycle that follows a cycle with `in_valid` low, and a synchronous reset clears it. When `out_valid` is low, `out_idx` is 0.
- R2: With one way (`in_ways`=1, `in_ntgt`=1), the index is 0 whatever the masks and address.
- R3: For 2, 4, 8 and 16 ways, index bit i equals the XOR-reduce of (address AND mask i), for i below log2(ways). Mask i occupies `in_mask[i*52 +: 52]`.
- R4: The number of masks in use is log2(ways) for power-of-two counts and log2(ways/3) for 3, 6 and 12 ways. Masks at or above that count do not affect the index, so 3 ways uses no mask.
- R5: For 3, 6 and 12 ways, the address with all bits below a lower bound cleared is reduced modulo 3. That remainder, shifted left by the mask count, is ORed with the parity bits.
- R6: The lower bound of the modulo field is log2(ways/3) + 8 + `in_genc`. Address bits below it do not change the remainder.
- R7: The address used is `in_base` + `in_pos` × 2^(`in_genc`+8), truncated to 52 bits.
- R8: If `in_ways` differs from `in_ntgt`, no valid target is returned: `out_valid` stays low one clock later.
- R9: A way count outside {1,2,3,4,6,8,12,16} returns no valid target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_base | input | 52 | Window base address |
| in_pos | input | 4 | Slot position within the interleave set |
| in_genc | input | 3 | Encoded granularity; bytes = 2^(in_genc+8) |
| in_ways | input | 5 | Interleave way count |
| in_ntgt | input | 5 | Number of configured targets |
| in_mask | input | 208 | Four 52-bit XOR masks, mask i at bits i*52 upward |
| out_valid | output | 1 | Registered result valid |
| out_idx | output | 4 | Registered target index |

## Verification
Random addresses with random masks are applied at every power-of-two way count. A wrong mask-to-bit mapping or a wrong mask count shows up as a flipped index bit. The 3, 6 and 12 way cases use random addresses and masks, plus addresses with a single bit just below and just at the modulo field's lower bound. Together these separate an OR of the remainder from a replacement of the parity bits, and separate a correct bound from an off-by-one. Stepping through positions at different granularities checks how the address is formed. Mismatched and unsupported way counts, and idle cycles between requests, check that the valid flag drops.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   // Sum of two residues modulo 3
   function automatic logic [1:0] res3_add(input logic [1:0] a, input logic [1:0] b);
      logic [2:0] s;
      s = {1'b0, a} + {1'b0, b};
      return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
   endfunction

   // Residue of a two-bit chunk value
   function automatic logic [1:0] res3_leaf(input logic [1:0] v);
      return (v == 2'd3) ? 2'd0 : v;
   endfunction

   typedef struct packed {
      logic       supported;
      logic       mod3;
      logic [2:0] nmaps;
   } way_info_t;

endpackage

// File: rtl/ilv_way_decode.sv
module ilv_way_decode #(
   parameter int WAYS_W = 5,
   parameter int NMAP   = 4
) (
   input  logic [WAYS_W-1:0] ways,
   input  logic [WAYS_W-1:0] ntgt,
   output ilv_pkg::way_info_t info,
   output logic              cfg_ok
);
   import ilv_pkg::*;

   always_comb begin
      info = '0;
      case (ways)
         WAYS_W'(1):  info = '{supported: 1'b1, mod3: 1'b0, nmaps: 3'd0};
         WAYS_W'(2):  info = '{supported: 1'b1, mod3: 1'b0, nmaps: 3'd1};
         WAYS_W'(4):  info = '{supported: 1'b1, mod3: 1'b0, nmaps: 3'd2};
         WAYS_W'(8):  info = '{supported: 1'b1, mod3: 1'b0, nmaps: 3'd3};
         WAYS_W'(16): info = '{supported: 1'b1, mod3: 1'b0, nmaps: 3'd4};
         WAYS_W'(3):  info = '{supported: 1'b1, mod3: 1'b1, nmaps: 3'd0};
         WAYS_W'(6):  info = '{supported: 1'b1, mod3: 1'b1, nmaps: 3'd1};
         WAYS_W'(12): info = '{supported: 1'b1, mod3: 1'b1, nmaps: 3'd2};
         default:     info = '0;
      endcase
   end

   assign cfg_ok = info.supported && (32'(info.nmaps) <= NMAP) && (ways == ntgt);
endmodule

// File: rtl/ilv_parity_bank.sv
module ilv_parity_bank #(
   parameter int ADDR_W = 52,
   parameter int NMAP   = 4
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [NMAP*ADDR_W-1:0] masks,
   input  logic [2:0]             nmaps,
   output logic [NMAP-1:0]        bits
);
   for (genvar i = 0; i < NMAP; i++) begin : g_map
      logic par;
      assign par     = ^(addr & masks[i*ADDR_W +: ADDR_W]);
      assign bits[i] = par && (32'(nmaps) > i);
   end
endmodule

// File: rtl/ilv_mod3_tree.sv
module ilv_mod3_tree #(
   parameter int W = 52
) (
   input  logic [W-1:0] val,
   output logic [1:0]   rem
);
   import ilv_pkg::*;

   localparam int NCHUNK = (W + 1) / 2;
   localparam int LEVELS = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
   localparam int LEAVES = 1 << LEVELS;
   localparam int NODES  = 2 * LEAVES - 1;
   localparam int PW     = 2 * NCHUNK;

   logic [PW-1:0]        padded;
   logic [2*NODES-1:0]   node;

   if (PW > W) begin : g_pad
      assign padded = {{(PW - W){1'b0}}, val};
   end else begin : g_nopad
      assign padded = val;
   end

   // Every chunk sits at weight 4^k, which is 1 modulo 3
   for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < NCHUNK) begin : g_live
         assign node[2*(LEAVES-1+k) +: 2] = res3_leaf(padded[2*k +: 2]);
      end else begin : g_zero
         assign node[2*(LEAVES-1+k) +: 2] = 2'd0;
      end
   end

   for (genvar j = 0; j < LEAVES - 1; j++) begin : g_add
      assign node[2*j +: 2] = res3_add(node[2*(2*j+1) +: 2], node[2*(2*j+2) +: 2]);
   end

   assign rem = node[1:0];
endmodule

// File: rtl/ilv_target_sel.sv
module ilv_target_sel #(
   parameter int ADDR_W = 52,
   parameter int NMAP   = 4,
   parameter int IDX_W  = 4,
   parameter int WAYS_W = 5,
   parameter int GENC_W = 3,
   parameter int POS_W  = 4,
   parameter int GRAN_BASE = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [ADDR_W-1:0]      in_base,
   input  logic [POS_W-1:0]       in_pos,
   input  logic [GENC_W-1:0]      in_genc,
   input  logic [WAYS_W-1:0]      in_ways,
   input  logic [WAYS_W-1:0]      in_ntgt,
   input  logic [NMAP*ADDR_W-1:0] in_mask,
   output logic                   out_valid,
   output logic [IDX_W-1:0]       out_idx
);
   import ilv_pkg::*;

   localparam int LO_W    = $clog2(ADDR_W + 1) + 1;
   localparam int IDX_MIN = (NMAP >= 2) ? ((NMAP > 4) ? NMAP : 4) : NMAP + 2;

   // Elaboration-time parameter checks
   if (NMAP < 1 || NMAP > 4) begin : g_bad_nmap
      $error("ilv_target_sel: NMAP must be 1..4");
   end
   if (IDX_W < IDX_MIN) begin : g_bad_idx
      $error("ilv_target_sel: IDX_W too narrow for NMAP");
   end
   if (ADDR_W < GRAN_BASE + (1 << GENC_W) + 4) begin : g_bad_addr
      $error("ilv_target_sel: ADDR_W too small for granularity range");
   end

   way_info_t        info;
   logic             cfg_ok;
   logic [ADDR_W-1:0] hpa;
   logic [NMAP-1:0]  par_bits;
   logic [LO_W-1:0]  lo;
   logic [ADDR_W-1:0] low_fill;
   logic [ADDR_W-1:0] mod_field;
   logic [1:0]       rem;
   logic [IDX_W-1:0] par_idx;
   logic [IDX_W-1:0] mod_idx;
   logic [IDX_W-1:0] idx_next;

   ilv_way_decode #(.WAYS_W(WAYS_W), .NMAP(NMAP)) u_dec (
      .ways  (in_ways),
      .ntgt  (in_ntgt),
      .info  (info),
      .cfg_ok(cfg_ok)
   );

   // Slot address: base plus position times granularity
   assign hpa = in_base + (ADDR_W'(in_pos) << (32'(in_genc) + GRAN_BASE));

   ilv_parity_bank #(.ADDR_W(ADDR_W), .NMAP(NMAP)) u_par (
      .addr (hpa),
      .masks(in_mask),
      .nmaps(info.nmaps),
      .bits (par_bits)
   );

   // Field for the remainder: all bits from the lower bound upward
   assign lo        = LO_W'(GRAN_BASE) + LO_W'(info.nmaps) + LO_W'(in_genc);
   assign low_fill  = (ADDR_W'(1) << lo) - ADDR_W'(1);
   assign mod_field = hpa & ~low_fill;

   ilv_mod3_tree #(.W(ADDR_W)) u_m3 (
      .val(mod_field),
      .rem(rem)
   );

   assign par_idx = IDX_W'(par_bits);
   assign mod_idx = info.mod3 ? (IDX_W'(rem) << info.nmaps) : '0;
   assign idx_next = par_idx | mod_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= in_valid && cfg_ok;
         out_idx   <= (in_valid && cfg_ok) ? idx_next : '0;
      end
   end
endmodule

// File: rtl/ilv_target_sel_chk.sv
module ilv_target_sel_chk #(
   parameter int WAYS_W = 5,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [WAYS_W-1:0] in_ways,
   input logic [WAYS_W-1:0] in_ntgt,
   input logic              out_valid,
   input logic [IDX_W-1:0]  out_idx
);
   // R1: no request, no result
   p_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R1: index is zero whenever no valid result
   p_zero_idx_r1: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> out_idx == '0);

   // R2: single way always selects target 0
   p_one_way_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ways == WAYS_W'(1) && in_ntgt == WAYS_W'(1)) |=> (out_valid && out_idx == '0));

   // R5: three ways gives an index below 3
   p_three_way_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ways == WAYS_W'(3) && in_ntgt == WAYS_W'(3)) |=> (out_valid && out_idx < IDX_W'(3)));

   // R8: mismatched target count gives no valid result
   p_mismatch_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ways != in_ntgt) |=> !out_valid);

   // R9: unsupported way count gives no valid result
   p_unsup_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_ways == WAYS_W'(5) || in_ways == WAYS_W'(0) || in_ways == WAYS_W'(7))) |=> !out_valid);
endmodule

bind ilv_target_sel ilv_target_sel_chk #(.WAYS_W(WAYS_W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ways  (in_ways),
   .in_ntgt  (in_ntgt),
   .out_valid(out_valid),
   .out_idx  (out_idx)
);

// File: tb/ilv_target_sel_test.sv
module ilv_target_sel_test;
   localparam int AW = 52;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [AW-1:0] in_base;
   logic [3:0]    in_pos;
   logic [2:0]    in_genc;
   logic [4:0]    in_ways;
   logic [4:0]    in_ntgt;
   logic [4*AW-1:0] in_mask;
   logic          out_valid;
   logic [3:0]    out_idx;

   logic [AW-1:0] m [4];
   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ilv_target_sel uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_base(in_base),
      .in_pos(in_pos), .in_genc(in_genc), .in_ways(in_ways), .in_ntgt(in_ntgt),
      .in_mask(in_mask), .out_valid(out_valid), .out_idx(out_idx)
   );

   assign in_mask = {m[3], m[2], m[1], m[0]};

   function automatic logic [AW-1:0] rnd52();
      return {20'($urandom), $urandom};
   endfunction

   function automatic bit ref_ok(input int w, input int n);
      return (w == n) && (w == 1 || w == 2 || w == 3 || w == 4 ||
                          w == 6 || w == 8 || w == 12 || w == 16);
   endfunction

   function automatic int ref_idx(input logic [AW-1:0] b, input int p, input int g, input int w);
      longint unsigned hpa, v;
      int nm;
      bit m3;
      int idx;
      int lo;
      hpa = (64'(b) + (64'(p) << (g + 8))) & ((64'd1 << AW) - 64'd1);
      m3 = (w == 3 || w == 6 || w == 12);
      case (w)
         2: nm = 1;  4: nm = 2;  8: nm = 3; 16: nm = 4;
         6: nm = 1; 12: nm = 2;
         default: nm = 0;
      endcase
      idx = 0;
      for (int i = 0; i < nm; i++)
         idx |= int'(^(hpa & 64'(m[i]))) << i;
      if (m3) begin
         lo = nm + 8 + g;
         v = (hpa >> lo) << lo;
         idx |= int'(v % 3) << nm;
      end
      return idx;
   endfunction

   task automatic check(input string tag, input logic av, input logic [3:0] ai,
                        input logic ev, input logic [3:0] ei);
      n_vec++;
      if (av !== ev || ai !== ei) begin
         n_fail++;
         $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d", tag, av, ai, ev, ei);
      end
   endtask

   // One request, result checked one clock later
   task automatic run_vec(input string tag, input logic [AW-1:0] b, input int p,
                          input int g, input int w, input int n);
      bit ok;
      @(negedge clk);
      in_valid = 1'b1;
      in_base  = b;
      in_pos   = 4'(p);
      in_genc  = 3'(g);
      in_ways  = 5'(w);
      in_ntgt  = 5'(n);
      ok = ref_ok(w, n);
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, out_valid, out_idx, ok, ok ? 4'(ref_idx(b, p, g, w)) : 4'd0);
   endtask

   task automatic rand_masks();
      for (int i = 0; i < 4; i++) m[i] = rnd52();
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b1; in_ways = 5'd2; in_ntgt = 5'd2;
      in_base = '1; in_pos = '0; in_genc = '0;
      repeat (3) @(negedge clk);
      check("R1 reset", out_valid, out_idx, 1'b0, 4'd0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_one_way();
      for (int k = 0; k < 6; k++) begin
         rand_masks();
         run_vec("R2 one way", rnd52(), k, k % 7, 1, 1);
      end
   endtask

   task automatic t_pow2();
      int ws [4] = '{2, 4, 8, 16};
      foreach (ws[j]) begin
         for (int k = 0; k < 12; k++) begin
            rand_masks();
            run_vec("R3 parity index", rnd52(), 0, 0, ws[j], ws[j]);
         end
      end
      // single-bit masks: index equals selected address bits (R4 upper masks ignored)
      m[0] = 52'h1 << 20; m[1] = 52'h1 << 21; m[2] = '1; m[3] = '1;
      run_vec("R4 unused masks", 52'h0030_0000, 0, 0, 4, 4);
      check("R4 literal", out_valid, out_idx, 1'b1, 4'd3);
   endtask

   task automatic t_mod3();
      int ws [3] = '{3, 6, 12};
      foreach (ws[j]) begin
         for (int k = 0; k < 12; k++) begin
            rand_masks();
            run_vec("R5 modulo term", rnd52(), k % 16, k % 7, ws[j], ws[j]);
         end
      end
      // 6 ways, mask 0 picks bit 0 set; address 2^12 -> field rem 1 -> idx 1|2 = 3
      m[0] = 52'h1; m[1] = '1; m[2] = '1; m[3] = '1;
      run_vec("R5 OR not replace", 52'h0000_0000_1001, 0, 3, 6, 6);
      check("R5 literal", out_valid, out_idx, 1'b1, 4'd3);
   endtask

   task automatic t_bound();
      for (int g = 0; g < 7; g++) begin
         for (int w = 0; w < 3; w++) begin
            int ways, lo;
            ways = (w == 0) ? 3 : (w == 1) ? 6 : 12;
            lo = w + 8 + g;
            for (int i = 0; i < 4; i++) m[i] = '0;
            run_vec("R6 below bound", 52'h1 << (lo - 1), 0, g, ways, ways);
            run_vec("R6 at bound",    52'h1 << lo,       0, g, ways, ways);
         end
      end
      // 3 ways, genc 0: bit 7 ignored, bit 8 -> 256 mod 3 = 1
      run_vec("R6 literal below", 52'h80, 0, 0, 3, 3);
      check("R6 literal below chk", out_valid, out_idx, 1'b1, 4'd0);
      run_vec("R6 literal at", 52'h100, 0, 0, 3, 3);
      check("R6 literal at chk", out_valid, out_idx, 1'b1, 4'd1);
   endtask

   task automatic t_pos();
      for (int g = 0; g < 7; g += 2) begin
         rand_masks();
         for (int p = 0; p < 16; p += 3) begin
            run_vec("R7 position addr", 52'h0_1234_5000_0000, p, g, 12, 12);
            run_vec("R7 position addr", 52'hF_FFFF_FFFF_0000, p, g, 8, 8);
         end
      end
   endtask

   task automatic t_mismatch();
      run_vec("R8 mismatch", rnd52(), 1, 1, 4, 8);
      run_vec("R8 mismatch", rnd52(), 1, 1, 3, 6);
      run_vec("R8 mismatch", rnd52(), 1, 1, 1, 2);
   endtask

   task automatic t_unsup();
      run_vec("R9 unsupported", rnd52(), 0, 0, 5, 5);
      run_vec("R9 unsupported", rnd52(), 0, 0, 0, 0);
      run_vec("R9 unsupported", rnd52(), 0, 0, 24, 24);
   endtask

   task automatic t_gap();
      rand_masks();
      run_vec("R1 latency", rnd52(), 2, 2, 16, 16);
      @(negedge clk);
      check("R1 idle after", out_valid, out_idx, 1'b0, 4'd0);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) m[i] = '0;
      t_reset();
      t_one_way();
      t_pow2();
      t_mod3();
      t_bound();
      t_pos();
      t_mismatch();
      t_unsup();
      t_gap();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule